// File: doc/BRIEF.md
# Automatic Buffered Serial Transfer Engine

This block is a three-wire synchronous serial master (clock out, data out, data in) that moves a whole run of bytes between a local buffer RAM and the serial line with a single software start. Software fills the buffer through a host port, programs how many bytes to move and how long to pause between bytes, sets the enable bit and writes the start register. The engine then fetches each transmit byte from the buffer, shifts it out most significant bit first while shifting a reply byte in, writes the reply back into the same buffer entry, idles for the programmed gap and moves on to the next entry.

A busy flag covers the whole multi-byte run, including the gaps, and is the intended completion indicator. An interrupt flag is raised on the same clock edge as the busy flag drops. While the engine is idle, the data output is held low and the serial clock rests high. While busy, the engine owns the buffer and host writes are dropped.

Top module: `auto_serial_engine`

## Requirements
- R1: After reset, sck_o is 1, sdo_o is 0, busy_o is 0 and irq_o is 0.
- R2: A write of any value to register address 3 starts a run only when bit 0 of register address 0 (enable) is 1. With the enable clear, busy_o stays 0 and sck_o does not toggle.
- R3: Each byte produces eight sck_o low pulses, each half period SCK_DIV clock cycles. sdo_o changes on the falling edge and sdi_i is sampled on the rising edge, bit 7 first.
- R4: Register address 1 holds the byte count minus one (N-1). Byte i of the run (i = 0..N-1) sends buffer entry i.
- R5: The byte received during byte i is written to buffer entry i. Entries at N and above are not modified.
- R6: Between consecutive bytes, sck_o stays high for exactly SCK_DIV + (IVL+1)*2*SCK_DIV + 4 clock cycles, where IVL is the value in register address 2.
- R7: busy_o (status register address 4, bit 0) is 1 from the edge that accepts the start until the edge that stores the last received byte. It stays 1 across all gaps, and sck_o rests high whenever busy_o is 0.
- R8: irq_o (status bit 1) is set on the edge where busy_o falls. Writing status with bit 1 set clears it. If the set and the clear fall on the same edge, the set wins.
- R9: One cycle after busy_o is 0, sdo_o is 0, even if the last bit sent was 1.
- R10: Start writes made while busy_o is 1 are ignored: the run still moves exactly N bytes.
- R11: Host buffer writes made while busy_o is 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| buf_we | input | 1 | Host buffer write strobe (dropped while busy) |
| buf_addr | input | ADDR_W | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer read data, one cycle after address |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| busy_o | output | 1 | Run in progress |
| irq_o | output | 1 | Run complete interrupt flag |

## Verification
The interrupt flag can be set by the final buffer store and cleared by a software status write on the same clock edge. The bench provokes this by counting the serial clock edges of the last byte. It then places the clearing write exactly on the edge where the last byte is stored. It judges the result by sampling after that edge: busy must already be low and the interrupt flag must still be high, because the set wins.

// File: rtl/ase_pkg.sv
// Package: shared register addresses and the sequencer state type.
// Assumes an 8-bit register data path and a 3-bit register address.
package ase_pkg;
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_LEN  = 3'd1;
    localparam logic [2:0] RA_GAP  = 3'd2;
    localparam logic [2:0] RA_GO   = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_STORE,
        SQ_GAP
    } sq_state_t;
endpackage

// File: rtl/ase_regfile.sv
// Register file: enable, length, gap and interrupt flag, plus the start pulse.
// Assumes IVL_W <= 8 and ADDR_W <= 8. Reads are combinational.
module ase_regfile #(
    parameter int ADDR_W = 5,
    parameter int IVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy_i,
    input  logic              irq_set_i,
    output logic              en_o,
    output logic [ADDR_W-1:0] len_o,
    output logic [IVL_W-1:0]  ivl_o,
    output logic              go_o,
    output logic              irq_o
);
    import ase_pkg::*;

    logic              en_q;
    logic [ADDR_W-1:0] len_q;
    logic [IVL_W-1:0]  ivl_q;
    logic              irq_q;
    logic              irq_clr;

    assign irq_clr = reg_we && (reg_addr == RA_STAT) && reg_wdata[1];

    // Purpose: hold the software-programmed settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            len_q <= '0;
            ivl_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: en_q  <= reg_wdata[0];
                RA_LEN:  len_q <= reg_wdata[ADDR_W-1:0];
                RA_GAP:  ivl_q <= reg_wdata[IVL_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: interrupt flag, where a set from the engine beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (irq_set_i) irq_q <= 1'b1;
        else if (irq_clr)   irq_q <= 1'b0;
    end

    // Purpose: read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {7'b0, en_q};
            RA_LEN:  reg_rdata = 8'(len_q);
            RA_GAP:  reg_rdata = 8'(ivl_q);
            RA_STAT: reg_rdata = {6'b0, irq_q, busy_i};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign go_o  = reg_we && (reg_addr == RA_GO) && en_q;
    assign en_o  = en_q;
    assign len_o = len_q;
    assign ivl_o = ivl_q;
    assign irq_o = irq_q;
endmodule

// File: rtl/ase_bufram.sv
// Buffer RAM: single port, synchronous read, DEPTH bytes.
// Assumes the caller multiplexes engine and host access onto the one port.
module ase_bufram #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Purpose: write on strobe and register the read data.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/ase_shifter.sv
// Byte shifter: drives sck low/high for eight bits, MSB first. Data changes on
// the falling edge and sdi is sampled on the rising edge. The half period is
// SCK_DIV clocks. done_o pulses one half period after the eighth rising edge.
// Assumes start_i is only pulsed while idle. hold_low_i forces sdo low.
module ase_shifter #(
    parameter int SCK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       hold_low_i,
    input  logic       sdi_i,
    output logic       sck_o,
    output logic       sdo_o,
    output logic [7:0] rx_o,
    output logic       done_o
);
    logic       active;
    logic       phase_hi;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic [7:0] rxreg;
    logic       sck_q;
    logic       sdo_q;
    logic       done_q;
    logic       tick;

    generate
        if (SCK_DIV == 1) begin : g_fast
            assign tick = 1'b1;
        end else begin : g_div
            localparam int HC_W = $clog2(SCK_DIV);
            logic [HC_W-1:0] hcnt;
            // Purpose: count clocks within one half period.
            always_ff @(posedge clk) begin
                if (!rst_n)                         hcnt <= '0;
                else if (start_i || !active || tick) hcnt <= '0;
                else                                hcnt <= hcnt + 1'b1;
            end
            assign tick = (hcnt == HC_W'(SCK_DIV - 1));
        end
    endgenerate

    // Purpose: bit sequencing, clock edges, data out and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            phase_hi <= 1'b0;
            bitn     <= '0;
            shreg    <= '0;
            rxreg    <= '0;
            sck_q    <= 1'b1;
            sdo_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                active   <= 1'b1;
                phase_hi <= 1'b0;
                bitn     <= '0;
                sck_q    <= 1'b0;
                sdo_q    <= tx_i[7];
                shreg    <= {tx_i[6:0], 1'b0};
            end else if (active && tick) begin
                if (!phase_hi) begin
                    sck_q    <= 1'b1;
                    rxreg    <= {rxreg[6:0], sdi_i};
                    phase_hi <= 1'b1;
                end else if (bitn == 3'd7) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    sck_q    <= 1'b0;
                    sdo_q    <= shreg[7];
                    shreg    <= {shreg[6:0], 1'b0};
                    bitn     <= bitn + 3'd1;
                    phase_hi <= 1'b0;
                end
            end
            if (hold_low_i) sdo_q <= 1'b0;
        end
    end

    assign sck_o  = sck_q;
    assign sdo_o  = sdo_q;
    assign rx_o   = rxreg;
    assign done_o = done_q;
endmodule

// File: rtl/ase_seq.sv
// Run sequencer: walks buffer entries 0..len, fetching, shifting, storing and
// inserting (IVL+1) serial clock periods of idle gap between bytes.
// Assumes the buffer read data is valid one cycle after the address.
module ase_seq #(
    parameter int ADDR_W  = 5,
    parameter int IVL_W   = 8,
    parameter int SCK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic [IVL_W-1:0]  ivl_i,
    input  logic              sh_done_i,
    input  logic [7:0]        sh_rx_i,
    input  logic [7:0]        ram_rdata_i,
    output logic              sh_start_o,
    output logic [7:0]        sh_tx_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              ram_we_o,
    output logic [7:0]        ram_wdata_o,
    output logic              busy_o,
    output logic              irq_set_o
);
    import ase_pkg::*;

    localparam int PERIOD = 2 * SCK_DIV;
    localparam int SUB_W  = $clog2(PERIOD);

    sq_state_t         state;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] last;
    logic [IVL_W-1:0]  ivl_q;
    logic [IVL_W-1:0]  per;
    logic [SUB_W-1:0]  sub;
    logic              busy_q;

    // Purpose: run state machine, entry index and gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            idx    <= '0;
            last   <= '0;
            ivl_q  <= '0;
            per    <= '0;
            sub    <= '0;
            busy_q <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: if (go_i) begin
                    idx    <= '0;
                    last   <= len_i;
                    ivl_q  <= ivl_i;
                    busy_q <= 1'b1;
                    state  <= SQ_FETCH;
                end
                SQ_FETCH: state <= SQ_LOAD;
                SQ_LOAD:  state <= SQ_SHIFT;
                SQ_SHIFT: if (sh_done_i) state <= SQ_STORE;
                SQ_STORE: begin
                    if (idx == last) begin
                        busy_q <= 1'b0;
                        state  <= SQ_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        per   <= ivl_q;
                        sub   <= '0;
                        state <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (sub == SUB_W'(PERIOD - 1)) begin
                        sub <= '0;
                        if (per == '0) state <= SQ_FETCH;
                        else           per   <= per - 1'b1;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign sh_start_o  = (state == SQ_LOAD);
    assign sh_tx_o     = ram_rdata_i;
    assign ram_addr_o  = idx;
    assign ram_we_o    = (state == SQ_STORE);
    assign ram_wdata_o = sh_rx_i;
    assign irq_set_o   = (state == SQ_STORE) && (idx == last);
    assign busy_o      = busy_q;
endmodule

// File: rtl/auto_serial_engine.sv
// Top: automatic buffered serial transfer engine. Joins the register file,
// sequencer, shifter and buffer RAM. The engine owns the RAM port while busy,
// and the host owns it otherwise. Assumes sdi_i is synchronous to clk.
module auto_serial_engine #(
    parameter int DEPTH   = 32,
    parameter int SCK_DIV = 2,
    parameter int IVL_W   = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic              sck_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              busy_o,
    output logic              irq_o
);
    logic              ctrl_en;
    logic [ADDR_W-1:0] len;
    logic [IVL_W-1:0]  ivl;
    logic              go;
    logic              irq_set;
    logic              busy;
    logic              sh_start;
    logic [7:0]        sh_tx;
    logic [7:0]        sh_rx;
    logic              sh_done;
    logic [ADDR_W-1:0] eng_addr;
    logic              eng_we;
    logic [7:0]        eng_wdata;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;

    ase_regfile #(.ADDR_W(ADDR_W), .IVL_W(IVL_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy_i(busy), .irq_set_i(irq_set),
        .en_o(ctrl_en), .len_o(len), .ivl_o(ivl), .go_o(go), .irq_o(irq_o)
    );

    ase_seq #(.ADDR_W(ADDR_W), .IVL_W(IVL_W), .SCK_DIV(SCK_DIV)) seq_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .len_i(len), .ivl_i(ivl),
        .sh_done_i(sh_done), .sh_rx_i(sh_rx), .ram_rdata_i(ram_rdata),
        .sh_start_o(sh_start), .sh_tx_o(sh_tx), .ram_addr_o(eng_addr),
        .ram_we_o(eng_we), .ram_wdata_o(eng_wdata), .busy_o(busy),
        .irq_set_o(irq_set)
    );

    ase_shifter #(.SCK_DIV(SCK_DIV)) shf_i (
        .clk(clk), .rst_n(rst_n), .start_i(sh_start), .tx_i(sh_tx),
        .hold_low_i(!busy), .sdi_i(sdi_i), .sck_o(sck_o), .sdo_o(sdo_o),
        .rx_o(sh_rx), .done_o(sh_done)
    );

    // Purpose: give the engine the RAM port while busy, the host otherwise.
    always_comb begin
        if (busy) begin
            ram_addr  = eng_addr;
            ram_we    = eng_we;
            ram_wdata = eng_wdata;
        end else begin
            ram_addr  = buf_addr;
            ram_we    = buf_we;
            ram_wdata = buf_wdata;
        end
    end

    ase_bufram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram_i (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    assign buf_rdata = ram_rdata;
    assign busy_o    = busy;
endmodule

// File: rtl/ase_chk.sv
// Checker: temporal properties of the engine's port behaviour, bound to the top.
module ase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       irq_o,
    input logic       sck_o,
    input logic       sdo_o,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic       ctrl_en
);
    import ase_pkg::*;

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(reg_we && (reg_addr == RA_GO) && ctrl_en));

    // R7
    idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sck_o);

    // R8
    irq_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> irq_o);

    // R9
    sdo_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !sdo_o);
endmodule

bind auto_serial_engine ase_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .irq_o(irq_o),
    .sck_o(sck_o), .sdo_o(sdo_o), .reg_we(reg_we), .reg_addr(reg_addr),
    .ctrl_en(ctrl_en)
);

// File: tb/auto_serial_engine_tb_top.sv
`timescale 1ns/1ps
module auto_serial_engine_tb_top;
    import ase_pkg::*;

    localparam int DEPTH   = 32;
    localparam int SCK_DIV = 2;
    localparam int ADDR_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_we;
    logic [2:0]        reg_addr;
    logic [7:0]        reg_wdata;
    logic [7:0]        reg_rdata;
    logic              buf_we;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_wdata;
    logic [7:0]        buf_rdata;
    logic              sck_o, sdo_o, sdi_i, busy_o, irq_o;

    always #2 clk = ~clk;

    auto_serial_engine #(.DEPTH(DEPTH), .SCK_DIV(SCK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .sck_o(sck_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .busy_o(busy_o),
        .irq_o(irq_o)
    );

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] exp_q[$];
    logic [7:0] reply_q[$];
    int         bytes_run = 0;
    int         cur_ivl   = 0;
    int         sbit = 0;
    int         pbit = 0;
    int         falls = 0;
    logic [7:0] scur = '0;
    logic [7:0] cap  = '0;
    time        t_rise = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave side: present reply bits on falling edges, check gap length.
    always @(negedge sck_o) begin
        if (rst_n === 1'b1) begin
            falls++;
            if (sbit == 0) begin
                if (bytes_run > 0)
                    chk("R6 inter-byte gap", 32'(($time - t_rise) / 4),
                        32'(SCK_DIV + (cur_ivl + 1) * 2 * SCK_DIV + 4));
                scur = (reply_q.size() > 0) ? reply_q.pop_front() : 8'h00;
            end
            sdi_i = scur[7 - sbit];
            sbit  = (sbit + 1) % 8;
        end
    end

    // Monitor: capture sdo on rising edges and compare against the scoreboard.
    always @(posedge sck_o) begin
        if (rst_n === 1'b1) begin
            t_rise = $time;
            cap    = {cap[6:0], sdo_o};
            pbit++;
            if (pbit == 8) begin
                pbit = 0;
                if (exp_q.size() == 0) begin
                    chk("R10 R4 extra byte on line", 32'(cap), 32'hFFFF_FFFF);
                end else begin
                    chk("R3 R4 serial byte MSB first", 32'(cap), 32'(exp_q.pop_front()));
                end
                chk("R7 busy during byte", 32'(busy_o), 32'd1);
                bytes_run++;
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic buf_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = ADDR_W'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic buf_rd(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = ADDR_W'(a);
        @(negedge clk);
        d = buf_rdata;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    // Driver: mode 0 plain, 1 pokes start and buffer mid-run, 2 collides irq clear.
    task automatic run_xfer(input int n, input int ivl, input int seed, input int mode);
        logic [7:0] tx [DEPTH];
        logic [7:0] rp [DEPTH];
        logic [7:0] rd;
        if (n < DEPTH) buf_wr(DEPTH - 1, 8'hE1);
        for (int i = 0; i < n; i++) begin
            tx[i] = 8'(i * 37 + seed * 11 + 5);
            if (i == n - 1) tx[i][0] = 1'b1;
            rp[i] = 8'(8'h5A ^ 8'(i * 13) ^ 8'(seed));
            buf_wr(i, tx[i]);
            exp_q.push_back(tx[i]);
            reply_q.push_back(rp[i]);
        end
        bytes_run = 0; cur_ivl = ivl; sbit = 0; pbit = 0;
        reg_wr(RA_LEN, 8'(n - 1));
        reg_wr(RA_GAP, 8'(ivl));
        reg_wr(RA_GO, 8'(seed));
        chk("R7 busy after start", 32'(busy_o), 32'd1);
        if (mode == 1) begin
            wait (bytes_run >= 1);
            reg_wr(RA_GO, 8'hFF);
            buf_wr(DEPTH - 1, 8'h77);
        end
        if (mode == 2) begin
            wait (bytes_run == n - 1);
            repeat (8) @(posedge sck_o);
            repeat (SCK_DIV + 1) @(posedge clk);
            @(negedge clk);
            reg_we = 1'b1; reg_addr = RA_STAT; reg_wdata = 8'h02;
            @(negedge clk);
            reg_we = 1'b0;
            chk("R8 busy falls on store edge", 32'(busy_o), 32'd0);
            chk("R8 set beats same-edge clear", 32'(irq_o), 32'd1);
        end
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R4 all bytes sent", 32'(exp_q.size()), 32'd0);
        chk("R10 byte count", 32'(bytes_run), 32'(n));
        chk("R8 irq after run", 32'(irq_o), 32'd1);
        chk("R7 busy clear after run", 32'(busy_o), 32'd0);
        chk("R9 sdo low when idle", 32'(sdo_o), 32'd0);
        for (int i = 0; i < n; i++) begin
            buf_rd(i, rd);
            chk("R5 received byte stored", 32'(rd), 32'(rp[i]));
        end
        if (n < DEPTH) begin
            buf_rd(DEPTH - 1, rd);
            chk("R5 R11 entry beyond count untouched", 32'(rd), 32'hE1);
        end
        reg_wr(RA_STAT, 8'h02);
        chk("R8 irq cleared by write", 32'(irq_o), 32'd0);
    endtask

    initial begin
        int f0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        buf_we = 1'b0; buf_addr = '0; buf_wdata = '0; sdi_i = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sck reset", 32'(sck_o), 32'd1);
        chk("R1 sdo reset", 32'(sdo_o), 32'd0);
        chk("R1 busy reset", 32'(busy_o), 32'd0);
        chk("R1 irq reset", 32'(irq_o), 32'd0);

        // Start with enable clear: nothing happens.
        f0 = falls;
        reg_wr(RA_GO, 8'hA5);
        repeat (40) @(negedge clk);
        chk("R2 disabled start ignored busy", 32'(busy_o), 32'd0);
        chk("R2 disabled start no clock", 32'(falls), 32'(f0));

        reg_wr(RA_CTRL, 8'h01);
        run_xfer(1, 0, 1, 0);
        run_xfer(6, 3, 2, 1);
        run_xfer(DEPTH, 1, 3, 0);
        run_xfer(2, 0, 4, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule